// File: doc/BRIEF.md
# Write-Twice Background Scroll Offset Bank

This block holds the horizontal and vertical scroll offsets of four background layers behind an 8-bit CPU write port. Each offset is 11 bits wide but sits at a single byte address. Software stores the low byte and then the high byte to the same address, and the second store completes the value. The block does not keep a separate holding byte for each register. Two internal byte latches are shared by every offset register, so any interleaved writes to other offsets also pass through them.

Every decoded write updates the addressed offset at once. The new value is built from the incoming byte and the latched earlier bytes. A horizontal offset takes its fine bits (the low three) and its coarse bits from different latches. A vertical offset takes the whole earlier byte. The held offsets drive parallel outputs that feed the display pipeline. Reads and the rendering that uses the offsets are outside this block.

Top module: `scroll_regbank`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears all eight offsets and both shared byte latches to zero.
- R2: Address decode: layer k (k = 1..4) has its horizontal offset at byte address 0x0B+2k and its vertical offset at 0x0C+2k. This places layer 4 horizontal at 0x13, and the decoded set is 0x0D to 0x14.
- R3: A write of byte D to a horizontal address sets that offset, at the next rising edge, to bits [10:0] of (D<<8) | (P & ~7) | (Q & 7). Here P is the first shared latch and Q is the second shared latch.
- R4: After a horizontal write, both shared latches hold D.
- R5: A write of byte D to a vertical address sets that offset to bits [10:0] of (D<<8) | P.
- R6: A vertical write loads D into the first latch only. The second latch keeps its value.
- R7: Two writes to one address, low byte L followed by high byte H with no write between them, leave the 11-bit value {H[2:0], L} in that offset, for both horizontal and vertical registers.
- R8: Writes to other offsets placed between the two halves change the result only through the shared latches, following R3 to R6 in the order the writes occur.
- R9: A write to an address outside 0x0D to 0x14, or any cycle with wr_en low, changes no offset and no latch.
- R10: A decoded write changes only the addressed offset. All other offsets keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one byte store per cycle |
| wr_addr | input | 8 | Byte address within the register page |
| wr_data | input | 8 | Byte being stored |
| bg1_hofs | output | 11 | Layer 1 horizontal offset |
| bg1_vofs | output | 11 | Layer 1 vertical offset |
| bg2_hofs | output | 11 | Layer 2 horizontal offset |
| bg2_vofs | output | 11 | Layer 2 vertical offset |
| bg3_hofs | output | 11 | Layer 3 horizontal offset |
| bg3_vofs | output | 11 | Layer 3 vertical offset |
| bg4_hofs | output | 11 | Layer 4 horizontal offset |
| bg4_vofs | output | 11 | Layer 4 vertical offset |

## Verification
The bench targets the asymmetry between the two latches. A horizontal write is placed right after a vertical write, so a design that also loads the second latch on vertical writes would produce the wrong fine bits. A design that swapped the latches in the horizontal merge would mix up coarse and fine bits. Interleaved half-writes to two different registers expose any per-register latching, because the completed value must take bits from the foreign byte. Writes at the addresses just outside the window, and writes with the strobe low, are each followed by writes whose results reveal both latches, so a decoder that is off by one or leaks writes is caught. A reset in the middle of the run is followed by writes whose results would show stale latch contents.

// File: rtl/scroll_pkg.sv
// scroll_pkg
// Shared types for the write-twice scroll offset bank.
// Assumes byte-wide CPU stores; the latch pair is shared by all offsets.
package scroll_pkg;

    localparam int BYTE_W = 8;

    // Which kind of offset an address selects.
    typedef enum logic {
        AXIS_HORIZ = 1'b0,
        AXIS_VERT  = 1'b1
    } axis_e;

    // The two shared byte latches.
    typedef struct packed {
        logic [BYTE_W-1:0] prev1;
        logic [BYTE_W-1:0] prev2;
    } byte_latch_t;

endpackage

// File: rtl/scroll_addr_decode.sv
// scroll_addr_decode
// Turns a byte address into a one-hot register select and an axis flag.
// Assumes registers are laid out from BASE_ADDR upward as
// horizontal, vertical pairs, one pair per layer.
module scroll_addr_decode
    import scroll_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_LAYERS = 4,
    parameter int BASE_ADDR  = 'h0D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    output logic                      hit,
    output axis_e                     axis,
    output logic [2*NUM_LAYERS-1:0]   sel
);

    localparam int NUM_REGS = 2 * NUM_LAYERS;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

    logic [ADDR_W-1:0] offs;

    // Distance of the address from the bottom of the register window.
    always_comb begin
        offs = wr_addr - BASE_A;
    end

    // A write hits when the strobe is high and the address is inside the window.
    always_comb begin
        hit  = wr_en && (wr_addr >= BASE_A) && (offs < NREG_A);
        axis = offs[0] ? AXIS_VERT : AXIS_HORIZ;
    end

    // One select line per register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = hit && (offs == ADDR_W'(i));
    end

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R9
    miss_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (sel == '0));

endmodule

// File: rtl/scroll_byte_latches.sv
// scroll_byte_latches
// Holds the two byte latches shared by all scroll offsets.
// Assumes the caller qualifies wr_hit with a decoded address.
module scroll_byte_latches
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  axis_e             axis,
    input  logic [BYTE_W-1:0] wr_data,
    output byte_latch_t       lat
);

    // Horizontal writes load both latches; vertical writes load only prev1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (wr_hit) begin
            lat.prev1 <= wr_data;
            if (axis == AXIS_HORIZ) begin
                lat.prev2 <= wr_data;
            end
        end
    end

    // R9
    idle_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(lat));

    // R6
    vert_keeps_prev2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && axis == AXIS_VERT) |=> $stable(lat.prev2));

    // R4
    horiz_latches_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && axis == AXIS_HORIZ) |=> (lat.prev1 == lat.prev2));

endmodule

// File: rtl/scroll_offset_bank.sv
// scroll_offset_bank
// Storage for every scroll offset and the merge that fills it.
// Assumes even indices are horizontal and odd indices are vertical,
// and that OFS_W does not exceed two bytes.
module scroll_offset_bank
    import scroll_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int OFS_W     = 11,
    parameter int FINE_BITS = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_REGS-1:0]                sel,
    input  logic [BYTE_W-1:0]                  wr_data,
    input  byte_latch_t                        lat,
    output logic [NUM_REGS-1:0][OFS_W-1:0]     ofs_q
);

    localparam int WIDE_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] FINE_MASK = BYTE_W'((1 << FINE_BITS) - 1);

    logic [WIDE_W-1:0] h_wide;
    logic [WIDE_W-1:0] v_wide;

    // Build both candidate values from the new byte and the shared latches.
    always_comb begin
        h_wide = {wr_data, (lat.prev1 & ~FINE_MASK) | (lat.prev2 & FINE_MASK)};
        v_wide = {wr_data, lat.prev1};
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [OFS_W-1:0] next_val;

        // Pick the merge rule by register kind.
        if (i % 2 == 0) begin : g_h
            assign next_val = h_wide[OFS_W-1:0];

            // R3
            fine_from_prev2_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sel[i] |=> (ofs_q[i][FINE_BITS-1:0] == $past(lat.prev2[FINE_BITS-1:0])));
        end else begin : g_v
            assign next_val = v_wide[OFS_W-1:0];

            // R5
            low_from_prev1_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sel[i] |=> (ofs_q[i][BYTE_W-1:0] == $past(lat.prev1)));
        end

        // Hold the offset and reload it on its own select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q[i] <= '0;
            end else if (sel[i]) begin
                ofs_q[i] <= next_val;
            end
        end

        // R10
        unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[i] |=> $stable(ofs_q[i]));

        // R7
        high_bits_from_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sel[i] |=> (ofs_q[i][OFS_W-1:BYTE_W] == $past(wr_data[OFS_W-BYTE_W-1:0])));
    end

endmodule

// File: rtl/scroll_regbank.sv
// scroll_regbank
// Write-twice scroll offset registers for four background layers behind
// one byte-wide write port. Assumes one store per strobed cycle.
module scroll_regbank
    import scroll_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int OFS_W     = 11,
    parameter int BASE_ADDR = 'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [OFS_W-1:0]  bg1_hofs,
    output logic [OFS_W-1:0]  bg1_vofs,
    output logic [OFS_W-1:0]  bg2_hofs,
    output logic [OFS_W-1:0]  bg2_vofs,
    output logic [OFS_W-1:0]  bg3_hofs,
    output logic [OFS_W-1:0]  bg3_vofs,
    output logic [OFS_W-1:0]  bg4_hofs,
    output logic [OFS_W-1:0]  bg4_vofs
);

    localparam int NUM_LAYERS = 4;
    localparam int NUM_REGS   = 2 * NUM_LAYERS;

    logic                              hit;
    axis_e                             axis;
    logic [NUM_REGS-1:0]               sel;
    byte_latch_t                       lat;
    logic [NUM_REGS-1:0][OFS_W-1:0]    ofs_q;

    scroll_addr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_LAYERS (NUM_LAYERS),
        .BASE_ADDR  (BASE_ADDR)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hit     (hit),
        .axis    (axis),
        .sel     (sel)
    );

    scroll_byte_latches u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hit),
        .axis    (axis),
        .wr_data (wr_data),
        .lat     (lat)
    );

    scroll_offset_bank #(
        .NUM_REGS (NUM_REGS),
        .OFS_W    (OFS_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_data (wr_data),
        .lat     (lat),
        .ofs_q   (ofs_q)
    );

    // Fan the stored offsets out to the per-layer ports.
    assign bg1_hofs = ofs_q[0];
    assign bg1_vofs = ofs_q[1];
    assign bg2_hofs = ofs_q[2];
    assign bg2_vofs = ofs_q[3];
    assign bg3_hofs = ofs_q[4];
    assign bg3_vofs = ofs_q[5];
    assign bg4_hofs = ofs_q[6];
    assign bg4_vofs = ofs_q[7];

    // R9
    miss_outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(ofs_q));

endmodule

// File: tb/sim_scroll_regbank.sv
// sim_scroll_regbank
// Directed bench: one task per scenario. Expected values are worked out
// by hand from the requirements.
module sim_scroll_regbank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [10:0] o0, o1, o2, o3, o4, o5, o6, o7;

    int n_chk = 0;
    int n_fail = 0;
    logic [10:0] expv [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_regbank u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data),
        .bg1_hofs (o0), .bg1_vofs (o1), .bg2_hofs (o2), .bg2_vofs (o3),
        .bg3_hofs (o4), .bg3_vofs (o5), .bg4_hofs (o6), .bg4_vofs (o7)
    );

    function automatic logic [10:0] get_out(int idx);
        case (idx)
            0: return o0;  1: return o1;  2: return o2;  3: return o3;
            4: return o4;  5: return o5;  6: return o6;  default: return o7;
        endcase
    endfunction

    task automatic check(string req, int idx, logic [10:0] act, logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s out%0d actual=0x%03h expected=0x%03h", req, idx, act, exp);
        end
    endtask

    // Compare all eight outputs; the one just written uses req, the rest R10.
    task automatic check_all(string req, int tgt);
        for (int i = 0; i < 8; i++) begin
            check((i == tgt) ? req : "R10", i, get_out(i), expv[i]);
        end
    endtask

    // One store. tgt is the expected index written (-1 for none), ev its value.
    task automatic wr(logic en, logic [7:0] a, logic [7:0] d, int tgt,
                      logic [10:0] ev, string req);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (tgt >= 0) expv[tgt] = ev;
        check_all(req, tgt);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) expv[i] = '0;
        check_all("R1", 99);
    endtask

    // R1: reset values
    task automatic t_reset_state();
        do_reset();
    endtask

    // R2, R3, R7: layer 4 horizontal at 0x13, low then high byte
    task automatic t_horiz_pair();
        wr(1'b1, 8'h13, 8'h34, 6, 11'h400, "R3");
        wr(1'b1, 8'h13, 8'h05, 6, 11'h534, "R7");
    endtask

    // R5, R7: layer 1 vertical at 0x0E
    task automatic t_vert_pair();
        wr(1'b1, 8'h0E, 8'h78, 1, 11'h005, "R5");
        wr(1'b1, 8'h0E, 8'h03, 1, 11'h378, "R7");
    endtask

    // R6: prev2 still 0x05 after vertical writes; prev1 is 0x03
    task automatic t_vert_keeps_prev2();
        wr(1'b1, 8'h0D, 8'hFF, 0, 11'h705, "R6");
    endtask

    // R4: horizontal write loaded both latches with 0xFF
    task automatic t_horiz_loads_both();
        wr(1'b1, 8'h10, 8'h00, 3, 11'h0FF, "R4");
        wr(1'b1, 8'h11, 8'h00, 4, 11'h007, "R4");
    endtask

    // R8: interleaved halves to two registers
    task automatic t_interleave();
        wr(1'b1, 8'h0F, 8'hAB, 2, 11'h300, "R8");
        wr(1'b1, 8'h12, 8'hCD, 5, 11'h5AB, "R8");
        wr(1'b1, 8'h0F, 8'h02, 2, 11'h2CB, "R8");
    endtask

    // R9: stray addresses and a strobe-low cycle, then reveal both latches
    task automatic t_ignored_writes();
        wr(1'b1, 8'h0C, 8'h55, -1, '0, "R9");
        wr(1'b1, 8'h15, 8'h55, -1, '0, "R9");
        wr(1'b1, 8'h00, 8'h55, -1, '0, "R9");
        wr(1'b1, 8'hFF, 8'h55, -1, '0, "R9");
        wr(1'b0, 8'h0D, 8'h55, -1, '0, "R9");
        wr(1'b1, 8'h14, 8'h01, 7, 11'h102, "R9");
        wr(1'b1, 8'h0D, 8'h00, 0, 11'h002, "R9");
    endtask

    // R1: reset clears latches too
    task automatic t_reset_clears_latches();
        wr(1'b1, 8'h0F, 8'h9A, 2, 11'h200, "R3");
        do_reset();
        wr(1'b1, 8'h0E, 8'h00, 1, 11'h000, "R1");
        wr(1'b1, 8'h0D, 8'h00, 0, 11'h000, "R1");
    endtask

    logic done = 1'b0;

    initial begin
        for (int i = 0; i < 8; i++) expv[i] = '0;
        t_reset_state();
        t_horiz_pair();
        t_vert_pair();
        t_vert_keeps_prev2();
        t_horiz_loads_both();
        t_interleave();
        t_ignored_writes();
        t_reset_clears_latches();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule